// File: doc/BRIEF.md
# Biphase-Mark Oversampling Bit Decoder

This block turns a biphase-mark serial line into a stream of decoded data bits. It uses only a free-running sample clock that runs several times faster than the line's bit rate. It needs no phase-locked loop and no clock recovery. The line level flips at the start of every bit cell, and a logic 1 adds a second flip in the middle of the cell. The decoder brings the line into the sample-clock domain and counts the sample clocks between flips. It sorts each interval as a half cell, a full cell, or an interval that is too long. A small pairing controller then turns those classes into bits.

The split between short and long intervals is not a fixed count. It follows a running estimate of the full-cell length, taken from the intervals themselves. The same logic therefore works for any ratio of sample clock to bit rate from 5 to 12. Intervals that break the coding rules raise a one-cycle violation strobe. This includes the stretched pulses that mark the start of a frame. A long silence raises a loss-of-signal level and returns the estimate to its start value.

Top module: `bmcDecoder`

## Requirements
- R1: The line is passed through two synchronizing flops. An edge is a change of the synchronized level. The interval is the number of sample clocks between two consecutive edges.
- R2: Each interval I is classed against the full-cell estimate E. The interval is short if 4·I ≤ 3·E. It is long if 3·E < 4·I ≤ 5·E. It is too long if 4·I > 5·E.
- R3: A long interval with no half cell pending produces bitOut = 0, together with a bitValid strobe one cycle wide.
- R4: Two consecutive short intervals produce bitOut = 1 with a bitValid strobe.
- R5: A short interval followed by a long one pulses violation for one cycle and emits no bit. Pairing then starts again from an empty state.
- R6: A too-long interval pulses violation, emits no bit, leaves E unchanged and clears any pending half cell.
- R7: E is kept with two fractional bits and starts at 8 samples. After each accepted interval, E becomes the mean of the old E and the interval's full-cell equivalent. The full-cell equivalent is I for a long interval and 2·I for a short one.
- R8: Bit streams whose cells last 5, 7, 8, 10 or 12 sample clocks decode to the transmitted bits. A cell with an odd length splits into halves of floor(R/2) and R − floor(R/2) clocks.
- R9: Suppose 32 sample clocks pass without an edge after the decoder has been armed. Then los goes to 1, E returns to 8 and the pairing clears. The first edge after that only re-arms the decoder and clears los. It emits neither a bit nor a violation.
- R10: An edge that lands in exactly the 32nd clock after the previous edge is classed as an interval, which is too long. It does not count as loss of signal.
- R11: After reset, los = 1, bitValid = 0, violation = 0 and bitOut = 0.
- R12: bitValid and violation never assert in the same cycle, and bitValid is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Raw biphase-mark line, asynchronous to clk |
| bitOut | output | 1 | Last decoded bit, valid when bitValid is high |
| bitValid | output | 1 | One-cycle strobe for each decoded bit |
| violation | output | 1 | One-cycle strobe for a coding violation |
| los | output | 1 | High while no signal is present |

## Verification
The interval classifier and the silence timer can both act in the same sample clock. This happens when an edge arrives in exactly the cycle where the counter reaches its limit. The bench sets this up after a loss of signal by arming the decoder and then leaving gaps of exactly 32 clocks and exactly 33 clocks before the next flip. A 32-clock gap must add one violation and leave los low. A 33-clock gap must raise los with no violation. Random streams with stretched pulses and broken half-cell pairs are also run at several ratios. For these, the count of decoded bits, their values and the count of violations are compared with what the encoder sent.

// File: rtl/bmcPkg.sv
package bmcPkg;

  // Classified interval, produced by the datapath on each synchronized edge
  typedef struct packed {
    logic edgeSeen;
    logic isShort;
    logic isLong;
    logic isTooLong;
    logic timeout;
  } ivlEvt_t;

  // Strobes from the control back to the datapath
  typedef struct packed {
    logic updShort;
    logic updLong;
    logic reseed;
  } ctlStb_t;

  typedef enum logic {
    PAIR_IDLE = 1'b0,
    PAIR_HALF = 1'b1
  } pairSt_t;

endpackage

// File: rtl/bmcDatapath.sv
module bmcDatapath
  import bmcPkg::*;
#(
  parameter int SEED        = 8,
  parameter int LOS_LIMIT   = 32,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(LOS_LIMIT + 1),
  parameter int FRAC        = 2,
  parameter int EST_W       = CNT_W + FRAC + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  ctlStb_t          ctl,
  output ivlEvt_t          evt,
  output logic             rxEdge,
  output logic [EST_W-1:0] estQ
);

  localparam int MW = EST_W + 4;
  localparam logic [EST_W-1:0] SEED_Q = EST_W'(SEED * (1 << FRAC));
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOS_LIMIT);

  // Synchronizer chain plus one history flop for edge detection
  logic [SYNC_STAGES:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], rxIn};
  end

  assign rxEdge = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];

  // Interval counter, saturating at the silence limit
  logic [CNT_W-1:0] ivlCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ivlCnt <= CNT_MAX;
    else if (rxEdge)           ivlCnt <= CNT_W'(1);
    else if (ivlCnt != CNT_MAX) ivlCnt <= ivlCnt + CNT_W'(1);
  end

  // Classification against scaled thresholds (interval in 1/16 units vs estimate in 1/4 units)
  logic [MW-1:0] ivlScaled, thrShort, thrLong;

  always_comb begin
    ivlScaled = MW'(ivlCnt) << (FRAC + 2);
    thrShort  = MW'(estQ) * MW'(3);
    thrLong   = MW'(estQ) * MW'(5);
  end

  logic shortHit, tooLongHit;
  assign shortHit   = (ivlScaled <= thrShort);
  assign tooLongHit = (ivlScaled >  thrLong);

  always_comb begin
    evt.edgeSeen  = rxEdge;
    evt.isShort   = rxEdge & shortHit;
    evt.isTooLong = rxEdge & tooLongHit;
    evt.isLong    = rxEdge & ~shortHit & ~tooLongHit;
    evt.timeout   = ~rxEdge & (ivlCnt == CNT_MAX);
  end

  // Full-cell estimate, averaged with each accepted interval
  logic [EST_W:0] sumLong, sumShort;

  always_comb begin
    sumLong  = {1'b0, estQ} + ((EST_W + 1)'(ivlCnt) << FRAC);
    sumShort = {1'b0, estQ} + ((EST_W + 1)'(ivlCnt) << (FRAC + 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             estQ <= SEED_Q;
    else if (ctl.reseed)   estQ <= SEED_Q;
    else if (ctl.updLong)  estQ <= sumLong[EST_W:1];
    else if (ctl.updShort) estQ <= sumShort[EST_W:1];
  end

endmodule

// File: rtl/bmcControl.sv
module bmcControl
  import bmcPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  ivlEvt_t evt,
  output ctlStb_t ctl,
  output logic    bitOut,
  output logic    bitValid,
  output logic    violation,
  output logic    los
);

  pairSt_t pairQ, pairN;
  logic    armedQ;
  logic    emitN, emitValN, violN, timeoutHit;

  always_comb begin
    pairN      = pairQ;
    emitN      = 1'b0;
    emitValN   = 1'b0;
    violN      = 1'b0;
    timeoutHit = 1'b0;
    ctl        = '0;

    if (evt.edgeSeen) begin
      if (armedQ) begin
        if (evt.isTooLong) begin
          violN = 1'b1;
          pairN = PAIR_IDLE;
        end else if (evt.isShort) begin
          ctl.updShort = 1'b1;
          if (pairQ == PAIR_HALF) begin
            emitN    = 1'b1;
            emitValN = 1'b1;
            pairN    = PAIR_IDLE;
          end else begin
            pairN = PAIR_HALF;
          end
        end else if (evt.isLong) begin
          ctl.updLong = 1'b1;
          if (pairQ == PAIR_HALF) begin
            violN = 1'b1;
            pairN = PAIR_IDLE;
          end else begin
            emitN    = 1'b1;
            emitValN = 1'b0;
          end
        end
      end
    end else if (armedQ && evt.timeout) begin
      timeoutHit = 1'b1;
      ctl.reseed = 1'b1;
      pairN      = PAIR_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairQ     <= PAIR_IDLE;
      armedQ    <= 1'b0;
      bitOut    <= 1'b0;
      bitValid  <= 1'b0;
      violation <= 1'b0;
      los       <= 1'b1;
    end else begin
      pairQ     <= pairN;
      bitValid  <= emitN;
      violation <= violN;
      if (emitN) bitOut <= emitValN;
      if (timeoutHit) begin
        armedQ <= 1'b0;
        los    <= 1'b1;
      end else if (evt.edgeSeen) begin
        armedQ <= 1'b1;
        los    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bmcDecoder.sv
module bmcDecoder
  import bmcPkg::*;
#(
  parameter int SEED        = 8,
  parameter int LOS_LIMIT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxIn,
  output logic bitOut,
  output logic bitValid,
  output logic violation,
  output logic los
);

  localparam int CNT_W = $clog2(LOS_LIMIT + 1);
  localparam int FRAC  = 2;
  localparam int EST_W = CNT_W + FRAC + 1;

  ivlEvt_t          evt;
  ctlStb_t          ctl;
  logic             rxEdge;
  logic [EST_W-1:0] estQ;

  bmcDatapath #(
    .SEED(SEED), .LOS_LIMIT(LOS_LIMIT), .SYNC_STAGES(SYNC_STAGES),
    .CNT_W(CNT_W), .FRAC(FRAC), .EST_W(EST_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .ctl(ctl),
    .evt(evt), .rxEdge(rxEdge), .estQ(estQ)
  );

  bmcControl uCtl (
    .clk(clk), .rstN(rstN), .evt(evt), .ctl(ctl),
    .bitOut(bitOut), .bitValid(bitValid), .violation(violation), .los(los)
  );

endmodule

// File: rtl/bmcChecker.sv
module bmcChecker #(
  parameter int SEED  = 8,
  parameter int EST_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitOut,
  input logic             bitValid,
  input logic             violation,
  input logic             los,
  input logic             rxEdge,
  input logic [EST_W-1:0] estQ
);

  localparam logic [EST_W-1:0] SEED_Q = EST_W'(SEED * 4);

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);                                   // R12

  AST_NO_BIT_WITH_VIOL: assert property (@(posedge clk) disable iff (!rstN)
    !(bitValid && violation));                                 // R12

  AST_LOS_RESEEDS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(los) |-> (estQ == SEED_Q));                          // R9

  AST_EDGE_CLEARS_LOS: assert property (@(posedge clk) disable iff (!rstN)
    (los && rxEdge) |=> !los);                                 // R9

  AST_NO_VIOL_IN_LOS: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> !los);                                       // R9

  AST_EST_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    estQ != '0);                                               // R7

  AST_BIT_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> $past(rxEdge));                               // R3

  AST_BITOUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |-> $stable(bitOut));                            // R4

endmodule

bind bmcDecoder bmcChecker #(.SEED(SEED), .EST_W(EST_W)) uChk (
  .clk(clk), .rstN(rstN), .bitOut(bitOut), .bitValid(bitValid),
  .violation(violation), .los(los), .rxEdge(rxEdge), .estQ(estQ)
);

// File: tb/sim_bmcDecoder.sv
`timescale 1ns/1ps
module sim_bmcDecoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b0;
  logic bitOut, bitValid, violation, los;

  always #5 clk = ~clk;

  bmcDecoder u0 (
    .clk(clk), .rstN(rstN), .rxIn(rxLine),
    .bitOut(bitOut), .bitValid(bitValid), .violation(violation), .los(los)
  );

  int checks = 0;
  int fails  = 0;
  int violCnt = 0;
  int expViol = 0;
  bit losSeen = 0;
  bit done = 0;
  bit gotQ[$];
  bit expQ[$];

  always @(negedge clk) begin
    if (rstN) begin
      if (bitValid) gotQ.push_back(bitOut);
      if (violation) violCnt++;
      if (los) losSeen = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tog();
    rxLine = ~rxLine;
  endtask

  // one biphase-mark cell of r sample clocks
  task automatic sendBit(input bit b, input int r);
    tog();
    if (b) begin
      waitCyc(r / 2);
      tog();
      waitCyc(r - r / 2);
    end else begin
      waitCyc(r);
    end
    expQ.push_back(b);
  endtask

  // stretched pulse, beyond 1.25 cells
  task automatic sendStretch(input int r);
    tog();
    waitCyc(r + r / 2 + 1);
    expViol++;
  endtask

  // half cell followed by a full cell
  task automatic sendBadPair(input int r);
    tog();
    waitCyc(r / 2);
    tog();
    waitCyc(r);
    expViol++;
  endtask

  function automatic bit pickBit();
    return 1'($urandom % 2);
  endfunction

  task automatic compareSegment(input string tag);
    chk(gotQ.size() == expQ.size(), {tag, " R8 bit count"}, gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++) begin
      if (expQ[i]) chk(gotQ[i] == expQ[i], {tag, " R4 one bit"}, gotQ[i], expQ[i]);
      else         chk(gotQ[i] == expQ[i], {tag, " R3 zero bit"}, gotQ[i], expQ[i]);
    end
    chk(violCnt == expViol, {tag, " R5 R6 violation count"}, violCnt, expViol);
    chk(los == 1'b1, {tag, " R9 los after silence"}, los, 1);
    gotQ.delete();
    expQ.delete();
    violCnt = 0;
    expViol = 0;
  endtask

  task automatic runSegment(input int r, input int nBits, input bit withErr, input string tag);
    for (int i = 0; i < 8; i++) sendBit(1'b1, r);   // training run of ones
    for (int i = 0; i < nBits; i++) begin
      if (withErr && ($urandom % 12 == 0)) begin
        if ($urandom % 2) sendStretch(r);
        else              sendBadPair(r);
      end
      sendBit(pickBit(), r);
    end
    tog();            // closes the last cell
    waitCyc(45);
    compareSegment(tag);
  endtask

  initial begin
    void'($urandom(32'd20240613));
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    chk(los == 1'b1,       "R11 los at reset", los, 1);
    chk(bitValid == 1'b0,  "R11 bitValid at reset", bitValid, 0);
    chk(violation == 1'b0, "R11 violation at reset", violation, 0);
    chk(bitOut == 1'b0,    "R11 bitOut at reset", bitOut, 0);

    // directed: all zeros and all ones at nominal ratio (R1 R2 R3 R4)
    for (int i = 0; i < 8; i++) sendBit(1'b1, 8);
    for (int i = 0; i < 12; i++) sendBit(1'b0, 8);
    for (int i = 0; i < 12; i++) sendBit(1'b1, 8);
    tog();
    waitCyc(45);
    compareSegment("R1 R2 directed ratio 8");

    // directed violations at ratio 8 (R5 R6)
    for (int i = 0; i < 8; i++) sendBit(1'b1, 8);
    sendBadPair(8);
    sendBit(1'b0, 8);
    sendStretch(8);
    sendBit(1'b1, 8);
    sendBit(1'b0, 8);
    tog();
    waitCyc(45);
    compareSegment("R5 R6 directed");

    // random streams at several ratios (R8); ratio 12 after 5 needs reseed (R9)
    runSegment(5,  150, 1'b0, "R8 ratio 5");
    runSegment(12, 150, 1'b0, "R8 R9 ratio 12 after 5");
    runSegment(8,  150, 1'b1, "R8 ratio 8 with errors");
    runSegment(7,  150, 1'b1, "R8 ratio 7 with errors");
    runSegment(10, 150, 1'b1, "R8 ratio 10 with errors");
    runSegment(5,  150, 1'b1, "R8 ratio 5 with errors");
    runSegment(12, 150, 1'b1, "R8 ratio 12 with errors");

    // R10: edge exactly at the silence limit vs one clock later
    tog();                     // arms only
    waitCyc(4);
    chk(los == 1'b0, "R9 first edge clears los", los, 0);
    chk(gotQ.size() == 0 && violCnt == 0, "R9 arming edge is silent", gotQ.size() + violCnt, 0);
    waitCyc(28);
    losSeen = 1'b0;
    tog();                     // gap of 32
    waitCyc(4);
    chk(violCnt == 1, "R10 gap 32 is a violation", violCnt, 1);
    chk(losSeen == 1'b0, "R10 gap 32 keeps los low", losSeen, 0);
    waitCyc(29);
    tog();                     // gap of 33
    waitCyc(4);
    chk(losSeen == 1'b1, "R10 gap 33 raises los", losSeen, 1);
    chk(violCnt == 1, "R10 gap 33 adds no violation", violCnt, 1);
    chk(gotQ.size() == 0, "R10 no bits from gaps", gotQ.size(), 0);
    waitCyc(45);
    gotQ.delete();
    violCnt = 0;

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule